// File: doc/BRIEF.md
# Two-Wire Command and Field-Strength Readout Slave

This block is the host-facing side of a low-power receiver. A host drives one serial clock line and a shared data line. The block only ever acts as a slave. Each write access carries one 8-bit command, MSB first. Bits are sampled on rising serial-clock edges, and a transfer opens with the first falling edge of the clock. When the eighth bit has arrived, the command is decoded into held control settings and one-cycle strobes: freeze the gain loop, choose the active receive channel, enter test mode, restart the gain counter, or reset the whole block.

A command with its read bit set takes a snapshot of the current 8-bit gain value and turns the data line around to output. The host then waits out an access delay and gives eight more clocks. The snapshot comes back MSB first, and the output bit changes only on falling clock edges. Both serial lines are oversampled by the system clock.

A stuck transfer can be cleared without touching the clock rhythm. The host holds the clock low and pulses the data line. Pad drivers are outside the block; it drives a data value and an output enable.

The controller has four states. ST_IDLE moves to ST_CMD on a clock fall. ST_CMD moves to ST_WAIT when it completes a read command, or back to ST_IDLE when it completes any other command. ST_WAIT moves to ST_READ when the access delay runs out. ST_READ moves to ST_IDLE after the eighth readout rise. An interface reset takes any state to ST_IDLE.

Top module: `twi_cmd_slave`

## Requirements
- R1: After reset the data output enable is low, freeze is 0, the channel select is 00, all three channel enables are 1, test mode is 0, and neither strobe is pulsing.
- R2: Command bits are taken on rising serial-clock edges, MSB first. Bit 7 sets freeze, bits 6:5 set the channel select, and bit 0 sets test mode. Bits 2:1 have no effect on any output.
- R3: A command acts only on its eighth rising edge. A partly shifted byte changes no output.
- R4: A completed command with bit 7 = 0 and bit 4 = 0 gives exactly one one-cycle gain-restart pulse. A command with bit 7 or bit 4 set gives none, unless bit 3 is set.
- R5: A command with bit 3 set clears freeze, channel select and test mode whatever its other bits are. It gives one soft-reset pulse and one gain-restart pulse at the same time, and it starts no readout.
- R6: A command with bit 4 = 1 and bit 3 = 0 captures the gain input at its eighth rising edge. The output enable rises right after that command and stays high until the eighth rising edge of the readout access.
- R7: Serial-clock edges that arrive within ACC_CYCLES system cycles after a read command are ignored.
- R8: During readout, the first falling edge presents bit 7 of the snapshot and each later falling edge presents the next lower bit. The output bit changes only after a falling edge.
- R9: While the serial clock is low, four rising edges on the data line return the interface to idle. Output enable drops and any partial byte is discarded. Freeze, channel select and test mode keep their values.
- R10: The channel select decodes to the enables {ch3,ch2,ch1} as follows: 00 gives 111, 01 gives 001, 10 gives 010, and 11 gives 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the host, idles high |
| sda_i | input | 1 | Data line level as seen at the pad, idles high |
| gain_i | input | GAIN_W | Live gain counter value to snapshot on read |
| sda_o | output | 1 | Readout bit to drive onto the data line |
| sda_oe_o | output | 1 | Enable for the data-line driver |
| freeze_o | output | 1 | Hold the gain loop at its present value |
| chan_sel_o | output | 2 | Held channel-select code |
| chan_en_o | output | 3 | Per-channel enables decoded from the select |
| test_mode_o | output | 1 | Test mode request |
| gain_rst_o | output | 1 | One-cycle pulse restarting the gain counter |
| soft_rst_o | output | 1 | One-cycle pulse resetting the receiver |

## Verification
The hardest situation to reach from the ports is a serial-clock edge that lands inside the access-delay window after a read command, because normal host pacing never produces one. A directed case does: it issues a read and then fires two short clock pulses before the delay expires. It then checks that the later eight-clock readout still returns the snapshot intact. Interface resets are also placed mid-byte and mid-readout, where the controller is deep in a transfer. Random command bytes from a fixed seed cover the mix of strobes and field combinations.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_READ
    } twi_state_e;

    // Field order is fixed by the serial command layout (MSB first on the wire).
    typedef struct packed {
        logic       freeze;
        logic [1:0] chan;
        logic       rd;
        logic       srst;
        logic [1:0] spare;
        logic       test;
    } twi_cmd_t;

    function automatic logic [2:0] chan_enables(input logic [1:0] sel);
        logic [2:0] en;
        unique case (sel)
            2'b00:   en = 3'b111;
            2'b01:   en = 3'b001;
            2'b10:   en = 3'b010;
            default: en = 3'b100;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{IDLE_LVL}};
            prev  <= IDLE_LVL;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl_o  = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
    assign fall_o = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/twi_bus_reset_det.sv
module twi_bus_reset_det #(
    parameter int PULSES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl_i,
    input  logic sda_rise_i,
    output logic bus_rst_o
);

    localparam int CNT_W = $clog2(PULSES + 1);

    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit = !scl_lvl_i && sda_rise_i && (cnt == CNT_W'(PULSES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bus_rst_o <= 1'b0;
        end else begin
            bus_rst_o <= hit;
            if (scl_lvl_i || hit) begin
                cnt <= '0;
            end else if (sda_rise_i) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/twi_ctrl_regs.sv
module twi_ctrl_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply_i,
    input  logic       freeze_i,
    input  logic [1:0] chan_i,
    input  logic       rd_i,
    input  logic       srst_i,
    input  logic       test_i,
    output logic       freeze_o,
    output logic [1:0] chan_o,
    output logic [2:0] chan_en_o,
    output logic       test_o,
    output logic       gain_rst_o,
    output logic       soft_rst_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freeze_o   <= 1'b0;
            chan_o     <= 2'b00;
            test_o     <= 1'b0;
            gain_rst_o <= 1'b0;
            soft_rst_o <= 1'b0;
        end else begin
            gain_rst_o <= 1'b0;
            soft_rst_o <= 1'b0;
            if (apply_i) begin
                if (srst_i) begin
                    freeze_o   <= 1'b0;
                    chan_o     <= 2'b00;
                    test_o     <= 1'b0;
                    gain_rst_o <= 1'b1;
                    soft_rst_o <= 1'b1;
                end else begin
                    freeze_o   <= freeze_i;
                    chan_o     <= chan_i;
                    test_o     <= test_i;
                    gain_rst_o <= !freeze_i && !rd_i;
                end
            end
        end
    end

    assign chan_en_o = twi_pkg::chan_enables(chan_o);

endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave #(
    parameter int SYNC_STAGES   = 2,
    parameter int ACC_CYCLES    = 50,
    parameter int BUSRST_PULSES = 4,
    parameter int GAIN_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic              sda_o,
    output logic              sda_oe_o,
    output logic              freeze_o,
    output logic [1:0]        chan_sel_o,
    output logic [2:0]        chan_en_o,
    output logic              test_mode_o,
    output logic              gain_rst_o,
    output logic              soft_rst_o
);

    import twi_pkg::*;

    localparam int MAX_BITS = (CMD_W > GAIN_W) ? CMD_W : GAIN_W;
    localparam int BIT_W    = $clog2(MAX_BITS);
    localparam int WAIT_W   = $clog2(ACC_CYCLES + 1);
    localparam logic [BIT_W-1:0] CMD_LAST = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0] RD_LAST  = BIT_W'(GAIN_W - 1);

    // ---- line conditioning: index 0 = clock, 1 = data
    logic [1:0] raw_lines;
    logic [1:0] line_lvl;
    logic [1:0] line_rise;
    logic [1:0] line_fall;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        twi_line_sync #(
            .STAGES  (SYNC_STAGES),
            .IDLE_LVL(1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .lvl_o (line_lvl[g]),
            .rise_o(line_rise[g]),
            .fall_o(line_fall[g])
        );
    end

    logic scl_rise, scl_fall, scl_lvl, sda_lvl, sda_rise;
    logic unused_sda_fall;
    assign scl_lvl         = line_lvl[0];
    assign scl_rise        = line_rise[0];
    assign scl_fall        = line_fall[0];
    assign sda_lvl         = line_lvl[1];
    assign sda_rise        = line_rise[1];
    assign unused_sda_fall = line_fall[1];

    logic bus_rst;

    twi_bus_reset_det #(
        .PULSES(BUSRST_PULSES)
    ) u_busrst (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl_i (scl_lvl),
        .sda_rise_i(sda_rise),
        .bus_rst_o (bus_rst)
    );

    // ---- datapath registers
    twi_state_e        state, state_nx;
    logic [BIT_W-1:0]  bit_cnt;
    logic [CMD_W-1:0]  cmd_sr;
    logic [GAIN_W-1:0] out_sr;
    logic [WAIT_W-1:0] wait_cnt;
    logic              lead_done;
    twi_cmd_t          word;
    logic              cmd_last;
    logic              apply;
    logic              go_read;
    logic              unused_spare;

    assign word         = twi_cmd_t'({cmd_sr[CMD_W-2:0], sda_lvl});
    assign go_read      = word.rd && !word.srst;
    assign unused_spare = ^word.spare;

    // ---- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---- next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (scl_fall) state_nx = ST_CMD;
            ST_CMD:  if (cmd_last) state_nx = go_read ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (wait_cnt == '0) state_nx = ST_READ;
            ST_READ: if (scl_rise && bit_cnt == RD_LAST) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
        if (bus_rst) state_nx = ST_IDLE;
    end

    // ---- outputs of the controller
    always_comb begin
        cmd_last = (state == ST_CMD) && scl_rise && (bit_cnt == CMD_LAST);
        apply    = cmd_last && !bus_rst;
        sda_oe_o = (state == ST_WAIT) || (state == ST_READ);
        sda_o    = out_sr[GAIN_W-1];
    end

    // ---- shift, count and delay registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            cmd_sr    <= '0;
            out_sr    <= '0;
            wait_cnt  <= '0;
            lead_done <= 1'b0;
        end else if (bus_rst) begin
            bit_cnt   <= '0;
            cmd_sr    <= '0;
            out_sr    <= '0;
            wait_cnt  <= '0;
            lead_done <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt   <= '0;
                    lead_done <= 1'b0;
                end
                ST_CMD: begin
                    if (scl_rise) begin
                        cmd_sr  <= {cmd_sr[CMD_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (cmd_last) begin
                        bit_cnt <= '0;
                        if (go_read) begin
                            out_sr   <= gain_i;
                            wait_cnt <= WAIT_W'(ACC_CYCLES - 1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
                end
                ST_READ: begin
                    if (scl_fall) begin
                        if (lead_done) out_sr <= {out_sr[GAIN_W-2:0], 1'b0};
                        lead_done <= 1'b1;
                    end
                    if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    twi_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply_i   (apply),
        .freeze_i  (word.freeze),
        .chan_i    (word.chan),
        .rd_i      (word.rd),
        .srst_i    (word.srst),
        .test_i    (word.test),
        .freeze_o  (freeze_o),
        .chan_o    (chan_sel_o),
        .chan_en_o (chan_en_o),
        .test_o    (test_mode_o),
        .gain_rst_o(gain_rst_o),
        .soft_rst_o(soft_rst_o)
    );

endmodule

// File: rtl/twi_cmd_slave_chk.sv
module twi_cmd_slave_chk (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sda_o,
    input logic                 sda_oe_o,
    input logic                 freeze_o,
    input logic [1:0]           chan_sel_o,
    input logic [2:0]           chan_en_o,
    input logic                 test_mode_o,
    input logic                 gain_rst_o,
    input logic                 soft_rst_o,
    input logic                 apply,
    input logic                 scl_fall
);

    AST_CHAN_EN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(chan_en_o) == 1) || (chan_en_o == 3'b111)); // R10

    AST_HOLD_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(freeze_o) && $stable(chan_sel_o) && $stable(test_mode_o))); // R3

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (!freeze_o && chan_sel_o == 2'b00 && !test_mode_o)); // R5

    AST_SRST_GAIN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> gain_rst_o); // R5

    AST_GAIN_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gain_rst_o |=> !gain_rst_o); // R4

    AST_OE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(apply)); // R6

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o && $past(sda_oe_o) && !$past(scl_fall)) |-> $stable(sda_o)); // R8

endmodule

bind twi_cmd_slave twi_cmd_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_o      (sda_o),
    .sda_oe_o   (sda_oe_o),
    .freeze_o   (freeze_o),
    .chan_sel_o (chan_sel_o),
    .chan_en_o  (chan_en_o),
    .test_mode_o(test_mode_o),
    .gain_rst_o (gain_rst_o),
    .soft_rst_o (soft_rst_o),
    .apply      (apply),
    .scl_fall   (scl_fall)
);

// File: tb/test_twi_cmd_slave.sv
module test_twi_cmd_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int ACC        = 50;
    localparam int SEED       = 32'h5EED_2025;
    localparam int N_RAND     = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [7:0] gain = 8'h00;
    logic       sda_o, sda_oe, freeze, test_mode, gain_rst, soft_rst;
    logic [1:0] chan;
    logic [2:0] chan_en;

    int checks = 0;
    int errors = 0;
    int gr_cnt = 0;
    int sr_cnt = 0;

    logic       e_freeze = 1'b0;
    logic [1:0] e_chan   = 2'b00;
    logic       e_test   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_cmd_slave #(.ACC_CYCLES(ACC)) i_twi_cmd_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .gain_i(gain),
        .sda_o(sda_o), .sda_oe_o(sda_oe), .freeze_o(freeze), .chan_sel_o(chan),
        .chan_en_o(chan_en), .test_mode_o(test_mode), .gain_rst_o(gain_rst),
        .soft_rst_o(soft_rst)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            gr_cnt <= gr_cnt + int'(gain_rst);
            sr_cnt <= sr_cnt + int'(soft_rst);
        end
    end

    function automatic logic [2:0] exp_en(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b111;
            2'b01:   return 3'b001;
            2'b10:   return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic int exp_gr(input logic [7:0] c);
        return (c[3] || (!c[7] && !c[4])) ? 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            scl = 1'b0; tick(HALF);
            sda = b[i]; tick(HALF);
            scl = 1'b1; tick(2*HALF);
        end
        sda = 1'b1; tick(2);
    endtask

    task automatic read_byte(output logic [7:0] v, output bit oe_ok);
        oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; tick(2*HALF);
            v[i] = sda_o;
            if (!sda_oe) oe_ok = 1'b0;
            scl = 1'b1; tick(2*HALF);
        end
    endtask

    task automatic bus_reset();
        scl = 1'b0; tick(HALF);
        repeat (4) begin
            sda = 1'b0; tick(3);
            sda = 1'b1; tick(3);
        end
        tick(HALF);
        scl = 1'b1; tick(2*HALF);
    endtask

    task automatic check_ctrl(input string req);
        check(freeze == e_freeze && chan == e_chan && test_mode == e_test, req,
              {freeze, chan, test_mode}, {e_freeze, e_chan, e_test});
        check(chan_en == exp_en(e_chan), "R10", chan_en, exp_en(e_chan));
    endtask

    // Sends a full command, updates the model and checks strobes, settings and turnaround.
    task automatic do_cmd(input logic [7:0] c, input string req);
        int gr0, sr0;
        gr0 = gr_cnt; sr0 = sr_cnt;
        send_bits(c, 8);
        tick(4);
        if (c[3]) begin
            e_freeze = 1'b0; e_chan = 2'b00; e_test = 1'b0;
        end else begin
            e_freeze = c[7]; e_chan = c[6:5]; e_test = c[0];
        end
        check_ctrl(req);
        check(gr_cnt - gr0 == exp_gr(c), "R4", gr_cnt - gr0, exp_gr(c));
        check(sr_cnt - sr0 == int'(c[3]), "R5", sr_cnt - sr0, int'(c[3]));
        check(sda_oe == (c[4] && !c[3]), "R6", sda_oe, (c[4] && !c[3]));
    endtask

    task automatic do_read(input logic [7:0] snap, input string req);
        logic [7:0] v;
        bit oe_ok;
        gain = ~snap;
        tick(ACC + 5);
        read_byte(v, oe_ok);
        check(v == snap, req, v, snap);
        check(oe_ok, "R6", oe_ok, 1);
        tick(4);
        check(!sda_oe, "R6", sda_oe, 0);
    endtask

    initial begin
        logic [7:0] c;
        logic [7:0] v;
        bit oe_ok;
        int s;
        s = $urandom(SEED);
        tick(3);
        check(!sda_oe, "R1", sda_oe, 0);
        rst_n = 1'b1;
        tick(4);
        check(!sda_oe && !gain_rst && !soft_rst, "R1", {sda_oe, gain_rst, soft_rst}, 0);
        check(!freeze && chan == 2'b00 && !test_mode, "R1", {freeze, chan, test_mode}, 0);
        check(chan_en == 3'b111, "R1", chan_en, 3'b111);

        // R10: all select codes
        for (int k = 0; k < 4; k++) do_cmd({1'b0, 2'(k), 5'b0}, "R10");
        // R2: spare bits ignored, test bit honoured, freeze honoured (R4: no restart)
        do_cmd(8'h06, "R2");
        do_cmd(8'h01, "R2");
        do_cmd(8'hC0, "R2");

        // R3: partial byte does nothing, then R9 interface reset discards it
        do_cmd(8'h40, "R2");
        send_bits(8'h9F, 7);
        tick(4);
        check_ctrl("R3");
        bus_reset();
        check(!sda_oe, "R9", sda_oe, 0);
        check_ctrl("R9");
        do_cmd(8'h21, "R9");

        // R7: clock edges inside the access delay are ignored
        gain = 8'hA5;
        do_cmd(8'h10, "R6");
        repeat (2) begin
            scl = 1'b0; tick(3);
            scl = 1'b1; tick(3);
        end
        tick(ACC);
        read_byte(v, oe_ok);
        check(v == 8'hA5, "R7", v, 8'hA5);
        tick(4);
        check(!sda_oe, "R7", sda_oe, 0);

        // R9: interface reset in the middle of a readout
        gain = 8'h3C;
        do_cmd(8'h30, "R6");
        tick(ACC + 5);
        for (int i = 0; i < 3; i++) begin
            scl = 1'b0; tick(2*HALF);
            scl = 1'b1; tick(2*HALF);
        end
        bus_reset();
        check(!sda_oe, "R9", sda_oe, 0);
        check_ctrl("R9");
        do_cmd(8'h00, "R9");

        // R5: soft reset wins over every other bit
        do_cmd(8'h61, "R2");
        do_cmd(8'hFF, "R5");

        // random commands
        for (int n = 0; n < N_RAND; n++) begin
            c = 8'($urandom);
            gain = 8'($urandom);
            v = gain;
            do_cmd(c, "R2");
            if (c[4] && !c[3]) do_read(v, "R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule